// File: doc/BRIEF.md
# Sampling Converter Conversion Sequencer with Serial Readout

This block is the digital control core of a 14-bit sampling converter. A conversion-start input and a mode select decide when a conversion begins. The block then drives the track/hold control and a busy flag, and it times the conversion with a cycle counter. When the counter expires, the block places the quantizer's result into a 16-bit output shift register. For now the result comes from a stub input port. A host reads the word out with an external serial clock. The register announces when it is driving through an output-enable line, which a pad cell uses to tri-state the serial data pin.

There are two operating modes. In high-throughput mode the falling edge of the start input begins the conversion and puts the track/hold into hold at once. In auto-shutdown mode the rising edge of the start input wakes the part. The track/hold keeps tracking for a fixed wake-up interval and only then enters hold. In both modes every falling edge of the start input returns the output register to a known empty state. The serial clock is oversampled on the system clock.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While reset is asserted and right after it, busy, holdOn and serOe are all 0.
- R2: In high-throughput mode (sleepMode=0), a falling edge of convStart seen while idle raises busy and holdOn in the following system cycle.
- R3: busy stays high for exactly CONV_CYCLES system cycles after the start in R2. In the cycle it falls, holdOn falls and serOe rises.
- R4: The loaded word is two zero bits followed by sampleCode, most significant bit first. serData shows bit 15 as soon as serOe rises, and it moves to the next bit on each falling edge of serClk.
- R5: serOe stays 1 through the first 15 falling serClk edges of a read. It drops after the 16th, and the register then holds zero.
- R6: The pulse count that ends a read runs from the last falling convStart edge. Falling serClk edges given while serOe is 0 (after a read, or during a conversion) advance it, so a read that follows k such edges ends after 16-k edges.
- R7: Any falling edge of convStart, in either mode and even during a read or a conversion, empties the output register and drops serOe in the next cycle.
- R8: In auto-shutdown mode (sleepMode=1), a rising edge of convStart seen while idle raises busy with holdOn still 0. holdOn rises WAKE_CYCLES cycles later and stays high for CONV_CYCLES cycles. busy and holdOn then fall together and the result is loaded.
- R9: convStart edges that arrive while busy is high neither restart nor extend the conversion. holdOn never falls while busy stays high.
- R10: A rising convStart edge in high-throughput mode, and a falling one in auto-shutdown mode, start no conversion. busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| convStart | input | 1 | Conversion start strobe, synchronous to clk |
| sleepMode | input | 1 | 0 selects high-throughput mode, 1 selects auto-shutdown mode |
| sampleCode | input | RES_W | Quantizer result (stub) |
| serClk | input | 1 | Host serial clock, oversampled on clk |
| busy | output | 1 | High while waking or converting |
| holdOn | output | 1 | 1 puts the track/hold into hold, 0 lets it track |
| serData | output | 1 | Serial output bit |
| serOe | output | 1 | Drive enable for the serial data pin |

## Verification
The high-throughput path runs on a table of codes chosen to tell faults apart: all zeros, all ones, both alternating patterns, a lone low bit and a lone high bit. Together they expose a swapped bit order, lost padding, stuck bits and an off-by-one shift. One entry toggles convStart during the conversion to show that the timing does not stretch. Directed cases cover the rest. A read is cut short by a falling start edge. A read is shortened by serial pulses given during an auto-shutdown conversion, which shows that the pulse counter is cleared only by the start edge. Start edges of the wrong polarity for the mode are also applied.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // strobes from the sequencer to the output register
  typedef struct packed {
    logic clear;  // empty register, restart pulse count
    logic load;   // capture a finished result
  } shiftStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_CONV = 2'd2
  } seqState_t;

endpackage

// File: rtl/edge_sense.sv
module edge_sense (
  input  logic clk,
  input  logic din,
  output logic rise,
  output logic fall
);

  // plain sampling flop: it follows din during reset as well, so no edge is
  // invented when reset releases
  logic dinQ;

  always_ff @(posedge clk) begin
    dinQ <= din;
  end

  assign rise = din & ~dinQ;
  assign fall = ~din & dinQ;

endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 50,
  parameter int WAKE_CYCLES = 50
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         convRise,
  input  logic         convFall,
  input  logic         sleepMode,
  output logic         busy,
  output logic         holdOn,
  output shiftStrobe_t strobe
);

  localparam int MAX_CYC = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES);
  localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             cntDone;

  assign cntDone = (cnt == CNT_LAST);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (!sleepMode && convFall) begin
          stateNext = ST_CONV;
          cntNext   = CONV_LOAD;
        end else if (sleepMode && convRise) begin
          stateNext = ST_WAKE;
          cntNext   = WAKE_LOAD;
        end
      end
      ST_WAKE: begin
        if (cntDone) begin
          stateNext = ST_CONV;
          cntNext   = CONV_LOAD;
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
      ST_CONV: begin
        if (cntDone) begin
          stateNext = ST_IDLE;
          cntNext   = '0;
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
      default: begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign busy         = (state != ST_IDLE);
  assign holdOn       = (state == ST_CONV);
  assign strobe.load  = (state == ST_CONV) && cntDone;
  assign strobe.clear = convFall;

endmodule

// File: rtl/out_shifter.sv
module out_shifter
  import adc_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RES_W  = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftStrobe_t     strobe,
  input  logic             serFall,
  input  logic [RES_W-1:0] code,
  output logic             serData,
  output logic             serOe
);

  localparam int PAD_W = WORD_W - RES_W;  // must be at least 1
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [BIT_W-1:0]  pulseCnt;
  logic              oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      pulseCnt <= '0;
      oeQ      <= 1'b0;
    end else if (strobe.clear) begin
      shiftReg <= '0;
      pulseCnt <= '0;
      oeQ      <= 1'b0;
    end else if (strobe.load) begin
      // the load leaves the pulse count where it is
      shiftReg <= {{PAD_W{1'b0}}, code};
      oeQ      <= 1'b1;
    end else if (serFall) begin
      if (pulseCnt == LAST_BIT) begin
        shiftReg <= '0;
        pulseCnt <= '0;
        oeQ      <= 1'b0;
      end else begin
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
        pulseCnt <= pulseCnt + BIT_W'(1);
      end
    end
  end

  assign serData = shiftReg[WORD_W-1];
  assign serOe   = oeQ;

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 50,
  parameter int WAKE_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic             sleepMode,
  input  logic [RES_W-1:0] sampleCode,
  input  logic             serClk,
  output logic             busy,
  output logic             holdOn,
  output logic             serData,
  output logic             serOe
);

  logic         convRise, convFall;
  logic         serRise, serFall;
  shiftStrobe_t strobe;

  edge_sense i_convEdge (
    .clk  (clk),
    .din  (convStart),
    .rise (convRise),
    .fall (convFall)
  );

  edge_sense i_serEdge (
    .clk  (clk),
    .din  (serClk),
    .rise (serRise),
    .fall (serFall)
  );

  conv_ctrl #(
    .CONV_CYCLES (CONV_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .convRise  (convRise),
    .convFall  (convFall),
    .sleepMode (sleepMode),
    .busy      (busy),
    .holdOn    (holdOn),
    .strobe    (strobe)
  );

  out_shifter #(
    .WORD_W (WORD_W),
    .RES_W  (RES_W)
  ) i_shift (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .serFall (serFall),
    .code    (sampleCode),
    .serData (serData),
    .serOe   (serOe)
  );

  // the host samples on rising serial edges; the data changes on falling ones
  logic unusedRise;
  assign unusedRise = serRise;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic sleepMode,
  input logic busy,
  input logic holdOn,
  input logic serOe
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!busy && !holdOn && !serOe));

  // R2
  fast_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !sleepMode && $fell(convStart)) |=> (busy && holdOn));

  // R3
  end_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !($past(convStart, 2) && !$past(convStart))) |-> (serOe && !holdOn));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convStart) |=> !serOe);

  // R8
  hold_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdOn |-> busy);

  // R8
  wake_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode && !busy && $rose(convStart)) |=> (busy && !holdOn));

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && holdOn) |=> (!busy || holdOn));

  // R10
  no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !sleepMode && $rose(convStart)) |=> !busy);

endmodule

bind adc_conv_sequencer adc_seq_checker i_seqChk (
  .clk       (clk),
  .rstN      (rstN),
  .convStart (convStart),
  .sleepMode (sleepMode),
  .busy      (busy),
  .holdOn    (holdOn),
  .serOe     (serOe)
);

// File: tb/test_adc_conv_sequencer.sv
module test_adc_conv_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int CONV_N     = 20;
  localparam int WAKE_N     = 12;
  localparam int NVEC       = 6;

  typedef struct packed {
    logic [13:0] code;
    logic        glitch;  // toggle convStart while busy
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{14'h0000, 1'b0},
    '{14'h3FFF, 1'b0},
    '{14'h2AAA, 1'b1},
    '{14'h1555, 1'b0},
    '{14'h0001, 1'b0},
    '{14'h2000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convStart = 1'b1;
  logic        sleepMode = 1'b0;
  logic [13:0] sampleCode = '0;
  logic        serClk = 1'b0;
  logic        busy, holdOn, serData, serOe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_conv_sequencer #(
    .RES_W       (14),
    .WORD_W      (16),
    .CONV_CYCLES (CONV_N),
    .WAKE_CYCLES (WAKE_N)
  ) i_adc_conv_sequencer (
    .clk        (clk),
    .rstN       (rstN),
    .convStart  (convStart),
    .sleepMode  (sleepMode),
    .sampleCode (sampleCode),
    .serClk     (serClk),
    .busy       (busy),
    .holdOn     (holdOn),
    .serData    (serData),
    .serOe      (serOe)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    serClk = 1'b1;
    @(negedge clk);
    serClk = 1'b0;
    @(negedge clk);
  endtask

  // read until serOe drops (bounded)
  task automatic readWord(output logic [15:0] bits, output int pulses);
    bits = '0;
    pulses = 0;
    while (serOe && pulses < 20) begin
      bits = {bits[14:0], serData};
      pulse();
      pulses++;
    end
  endtask

  // high-throughput conversion; ends one cycle after result load
  task automatic runFast(input logic [13:0] code, input bit glitch);
    int busyLow = 0;
    sampleCode = code;
    @(negedge clk);
    convStart = 1'b0;
    @(negedge clk);
    chk("R2 busy after fall", busy, 1);
    chk("R2 hold after fall", holdOn, 1);
    for (int i = 1; i < CONV_N; i++) begin
      if (glitch && i == 3) convStart = 1'b1;
      if (glitch && i == 5) convStart = 1'b0;
      @(negedge clk);
      if (!busy || !holdOn) busyLow++;
    end
    chk(glitch ? "R9 busy kept through toggles" : "R3 busy held", busyLow, 0);
    @(negedge clk);
    chk("R3 busy falls", busy, 0);
    chk("R3 hold falls", holdOn, 0);
    chk("R3 output enabled", serOe, 1);
    convStart = 1'b1;
    @(negedge clk);
    chk("R10 rising edge fast mode no start", busy, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] got;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 hold in reset", holdOn, 0);
    chk("R1 oe in reset", serOe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 oe after reset", serOe, 0);

    // vector table, high-throughput mode
    for (int v = 0; v < NVEC; v++) begin
      runFast(VECS[v].code, VECS[v].glitch);
      readWord(got, n);
      chk("R4 word content", int'(got), int'({2'b00, VECS[v].code}));
      chk("R5 read length", n, 16);
      chk("R5 oe low after read", serOe, 0);
      // extra pulses past the read; cleared by the next start edge (R6)
      pulse();
      pulse();
    end

    // R7: falling start edge in the middle of a read
    runFast(14'h1234, 1'b0);
    repeat (5) pulse();
    chk("R7 oe still high mid-read", serOe, 1);
    sampleCode = 14'h0F0F;
    convStart = 1'b0;
    @(negedge clk);
    chk("R7 oe dropped by start edge", serOe, 0);
    chk("R2 new conversion started", busy, 1);
    repeat (CONV_N - 1) @(negedge clk);
    @(negedge clk);
    chk("R3 oe after interrupted run", serOe, 1);
    convStart = 1'b1;
    readWord(got, n);
    chk("R6 full read after clear", n, 16);
    chk("R4 word after interrupted run", int'(got), int'({2'b00, 14'h0F0F}));

    // leave a loaded result, then switch to auto-shutdown mode
    runFast(14'h0ABC, 1'b0);
    sleepMode = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    @(negedge clk);
    chk("R10 falling edge sleep mode no start", busy, 0);
    chk("R7 falling edge clears loaded word", serOe, 0);
    @(negedge clk);
    chk("R10 still idle", busy, 0);

    // auto-shutdown conversions: extra = 0 and 3
    for (int k = 0; k < 2; k++) begin
      int extra = k * 3;
      int trackBad = 0;
      int holdBad = 0;
      logic [13:0] code = (k == 0) ? 14'h2B3C : 14'h35A5;
      sampleCode = code;
      convStart = 1'b1;
      @(negedge clk);
      chk("R8 busy on wake", busy, 1);
      chk("R8 tracking on wake", holdOn, 0);
      for (int i = 1; i < WAKE_N; i++) begin
        if (i == 2) convStart = 1'b0;
        @(negedge clk);
        if (holdOn || !busy) trackBad++;
      end
      chk("R8 tracking through wake", trackBad, 0);
      @(negedge clk);
      chk("R8 hold after wake delay", holdOn, 1);
      for (int i = 1; i < CONV_N; i++) begin
        if (i <= 2 * extra) serClk = (i % 2 == 1);
        @(negedge clk);
        if (!holdOn || !busy) holdBad++;
      end
      chk("R8 hold through conversion", holdBad, 0);
      @(negedge clk);
      chk("R8 busy falls", busy, 0);
      chk("R8 hold falls", holdOn, 0);
      chk("R8 result loaded", serOe, 1);
      readWord(got, n);
      chk("R6 read length after pulses", n, 16 - extra);
      chk("R6 bits read", int'(got), int'({2'b00, code} >> extra));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule